// File: doc/BRIEF.md
# Receive Descriptor Chain DMA Engine

This block moves received frames from a word-wide stream into system memory. Memory holds a singly linked chain of three-word frame descriptors. Each descriptor names a buffer and a successor. The engine prefetches a descriptor and checks whether it holds ownership of it. It then writes each arriving frame word into the buffer and records the frame outcome in the descriptor. After that it hands the descriptor back to software and moves along the chain. Software prepares the chain, programs the start pointer and the per-buffer word limit, and raises the enable.

The descriptor layout uses byte offsets from the descriptor address. Offset 0 holds the buffer address, with ownership in bit 31 (1 = engine, 0 = software). Offset 4 receives the status word. Offset 8 holds the next-descriptor pointer, where zero means end of chain. The memory port issues one single-word read or write per cycle. A read returns its data one cycle after the request. The frame stream has no backpressure, so any word the engine cannot take is dropped.

Top module: `rxdesc_dma`

## Requirements
- R1: After reset, mem_rd, mem_wr and irq are low, and while cfg_rx_en is low the engine issues no memory access.
- R2: When cfg_rx_en rises, the engine reads the descriptor at cfg_desc_start: offset 0 (bit 31 ownership, bits 30:0 buffer address) and offset 8 (next pointer). Each descriptor costs exactly two reads, and reads and writes never coincide.
- R3: Word i of an accepted frame, for i below cfg_max_words, is written to buffer address + 4*i.
- R4: Every word past the limit is written to buffer address + 4*(cfg_max_words-1). The final content of that location is the frame's last word.
- R5: At frame end, the word at descriptor + 4 is written with these fields: bits 15:0 the number of words received, bit 16 set when neither error nor overflow occurred, bit 18 set when in_err accompanied any word, and bit 19 set on overflow. All other bits are zero.
- R6: After the status write, offset 0 is rewritten with bit 31 cleared and the address bits kept, and irq pulses high for exactly one cycle.
- R7: The engine then follows the next pointer. A null pointer halts it. While halted, frames cause no memory write. Clearing and then setting cfg_rx_en restarts the engine from cfg_desc_start.
- R8: With cfg_skip_unowned = 1, a descriptor with bit 31 clear is left untouched and the engine moves to its next pointer without an interrupt.
- R9: With cfg_skip_unowned = 0, a descriptor with bit 31 clear raises a one-cycle irq and halts the engine with no write.
- R10: A frame whose first word arrives while the engine is not waiting for a frame is discarded whole, including words that arrive after the engine becomes ready.
- R11: Clearing cfg_rx_en during a frame lets that frame complete, including status and ownership release. The engine then stops, and later frames are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_skip_unowned | input | 1 | 1: skip a software-owned descriptor; 0: interrupt and halt |
| cfg_desc_start | input | 32 | Byte address of the first descriptor |
| cfg_max_words | input | LEN_W | Buffer capacity in words (at least 1) |
| in_valid | input | 1 | Frame word present |
| in_data | input | 32 | Frame word |
| in_last | input | 1 | Final word of the frame |
| in_err | input | 1 | Error reported with this word |
| mem_rd | output | 1 | Single-word read request |
| mem_wr | output | 1 | Single-word write request |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume the following about the inputs. cfg_max_words is nonzero and does not change while the engine is enabled. Buffer and descriptor addresses are word aligned. Memory returns read data exactly one cycle after a request. The bench keeps to these rules: it changes configuration only while the enable is low, draws limits from 4 to 12 words, places all structures on word boundaries, and leaves at least fifteen idle cycles between frames, so that every intended frame meets a ready engine.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;
  localparam int WORD_W  = 32;
  localparam int OWN_BIT = 31;
  localparam int LEN_FLD = 16;
  localparam int ST_GOOD = 16;
  localparam int ST_ERR  = 18;
  localparam int ST_OVF  = 19;
  localparam logic [WORD_W-1:0] OFS_STAT = 32'd4;
  localparam logic [WORD_W-1:0] OFS_NEXT = 32'd8;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD2, S_CAP0, S_CAP2, S_READY,
    S_RECV, S_WSTAT, S_WOWN, S_ADV, S_HALT
  } rx_state_e;
endpackage

// File: rtl/rxd_sof_trk.sv
`timescale 1ns/1ps
module rxd_sof_trk (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_last,
  output logic sof
);
  logic mid_q;

  always_ff @(posedge clk) begin
    if (rst) mid_q <= 1'b0;
    else if (in_valid) mid_q <= !in_last;
  end

  assign sof = in_valid && !mid_q;
endmodule

// File: rtl/rxd_word_cnt.sv
`timescale 1ns/1ps
module rxd_word_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic [LEN_W-1:0] max_words,
  output logic [LEN_W-1:0] widx,
  output logic [LEN_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic at_cap;

  assign at_cap = (cnt_q >= max_words);
  assign widx   = start ? '0 : (at_cap ? max_words - 1'b1 : cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (start) begin
      cnt_q <= {{(LEN_W-1){1'b0}}, 1'b1};
      ovf_q <= 1'b0;
    end else if (step) begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (at_cap) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxdesc_dma.sv
`timescale 1ns/1ps
module rxdesc_dma
  import rxd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rx_en,
  input  logic              cfg_skip_unowned,
  input  logic [WORD_W-1:0] cfg_desc_start,
  input  logic [LEN_W-1:0]  cfg_max_words,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              irq
);
  rx_state_e         st_q;
  logic [WORD_W-1:0] desc_q, buf_q, next_q;
  logic              own_q, err_q, wr_data_q;
  logic              sof, start, step, ovf_q;
  logic [LEN_W-1:0]  widx, cnt_q;
  logic [WORD_W-1:0] stat_w, data_addr, lim_bytes;

  rxd_sof_trk u_sof (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last), .sof(sof)
  );

  assign start = (st_q == S_READY) && cfg_rx_en && sof;
  assign step  = (st_q == S_RECV) && in_valid;

  rxd_word_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .step(step),
    .max_words(cfg_max_words), .widx(widx), .cnt_q(cnt_q), .ovf_q(ovf_q)
  );

  assign data_addr = buf_q + WORD_W'({widx, 2'b00});
  assign lim_bytes = WORD_W'({cfg_max_words, 2'b00});

  always_comb begin
    stat_w              = '0;
    stat_w[LEN_FLD-1:0] = LEN_FLD'(cnt_q);
    stat_w[ST_OVF]      = ovf_q;
    stat_w[ST_ERR]      = err_q;
    stat_w[ST_GOOD]     = !ovf_q && !err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      irq       <= 1'b0;
      desc_q    <= '0;
      buf_q     <= '0;
      next_q    <= '0;
      own_q     <= 1'b0;
      err_q     <= 1'b0;
      wr_data_q <= 1'b0;
    end else begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      irq       <= 1'b0;
      wr_data_q <= 1'b0;
      case (st_q)
        S_IDLE: if (cfg_rx_en) begin
          desc_q <= cfg_desc_start;
          st_q   <= S_RD0;
        end
        S_RD0: begin
          mem_rd   <= 1'b1;
          mem_addr <= desc_q;
          st_q     <= S_RD2;
        end
        S_RD2: begin
          mem_rd   <= 1'b1;
          mem_addr <= desc_q + OFS_NEXT;
          st_q     <= S_CAP0;
        end
        S_CAP0: begin
          own_q <= mem_rdata[OWN_BIT];
          buf_q <= {1'b0, mem_rdata[OWN_BIT-1:0]};
          st_q  <= S_CAP2;
        end
        S_CAP2: begin
          next_q <= mem_rdata;
          if (own_q) st_q <= S_READY;
          else if (cfg_skip_unowned) begin
            desc_q <= mem_rdata;
            st_q   <= (mem_rdata == '0) ? S_HALT : S_RD0;
          end else begin
            irq  <= 1'b1;
            st_q <= S_HALT;
          end
        end
        S_READY: begin
          if (!cfg_rx_en) st_q <= S_IDLE;
          else if (start) begin
            mem_wr    <= 1'b1;
            wr_data_q <= 1'b1;
            mem_addr  <= data_addr;
            mem_wdata <= in_data;
            err_q     <= in_err;
            st_q      <= in_last ? S_WSTAT : S_RECV;
          end
        end
        S_RECV: if (in_valid) begin
          mem_wr    <= 1'b1;
          wr_data_q <= 1'b1;
          mem_addr  <= data_addr;
          mem_wdata <= in_data;
          err_q     <= err_q | in_err;
          if (in_last) st_q <= S_WSTAT;
        end
        S_WSTAT: begin
          mem_wr    <= 1'b1;
          mem_addr  <= desc_q + OFS_STAT;
          mem_wdata <= stat_w;
          st_q      <= S_WOWN;
        end
        S_WOWN: begin
          mem_wr    <= 1'b1;
          mem_addr  <= desc_q;
          mem_wdata <= {1'b0, buf_q[OWN_BIT-1:0]};
          irq       <= 1'b1;
          st_q      <= S_ADV;
        end
        S_ADV: begin
          desc_q <= next_q;
          if (next_q == '0) st_q <= S_HALT;
          else if (cfg_rx_en) st_q <= S_RD0;
          else st_q <= S_IDLE;
        end
        S_HALT: if (!cfg_rx_en) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr && mem_rd)); // R2
  AST_DATA_IN_BUF: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && wr_data_q) |-> ((mem_addr - buf_q) < lim_bytes)); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R6
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_HALT) |-> !mem_wr); // R7
endmodule

// File: tb/rxdesc_dma_tb_top.sv
`timescale 1ns/1ps
module rxdesc_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_rx_en = 1'b0;
  logic        cfg_skip_unowned = 1'b0;
  logic [31:0] cfg_desc_start = '0;
  logic [15:0] cfg_max_words = 16'd8;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_err = 1'b0;
  logic        mem_rd, mem_wr, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:1023];
  logic [31:0] frame_d [0:31];
  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, rd_cnt = 0, irq_cnt = 0;

  always #10 clk = ~clk;

  rxdesc_dma #(.LEN_W(16)) dut_i (
    .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_skip_unowned(cfg_skip_unowned),
    .cfg_desc_start(cfg_desc_start), .cfg_max_words(cfg_max_words),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (mem_wr) begin
      mem[mem_addr[11:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[11:2]];
      rd_cnt <= rd_cnt + 1;
    end
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  function automatic logic [31:0] sentinel(input logic [31:0] a);
    return 32'h5A00_0000 | (a >> 2);
  endfunction

  function automatic logic [31:0] exp_status(input int n, input int mx, input bit err);
    bit ovf = (n > mx);
    return (32'(ovf) << 19) | (32'(err) << 18) | (32'(!ovf && !err) << 16) | 32'(n & 16'hFFFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) mem[i] = sentinel(32'(i) << 2);
  endtask

  task automatic set_desc(input logic [31:0] a, input bit own, input logic [31:0] b, input logic [31:0] nx);
    mem[a[11:2]]      = {own, b[30:0]};
    mem[a[11:2] + 1]  = 32'h0;
    mem[a[11:2] + 2]  = nx;
  endtask

  task automatic fill_frame(input int n);
    for (int i = 0; i < n; i++) frame_d[i] = $urandom;
  endtask

  task automatic send_frame(input int n, input int err_at);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = frame_d[i];
      in_last = (i == n - 1); in_err = (i == err_at);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
  endtask

  task automatic check_frame(input logic [31:0] d, input logic [31:0] b, input int n, input int mx, input bit err);
    for (int j = 0; j < mx; j++) begin
      logic [31:0] e;
      logic [31:0] a = b + 32'(j * 4);
      e = sentinel(a);
      if (j == mx - 1 && n >= mx) e = frame_d[n-1];
      else if (j < n) e = frame_d[j];
      chk((j == mx - 1 && n > mx) ? "R4 clamp word" : "R3 data word", mem[a[11:2]], e);
    end
    chk("R5 status", mem[d[11:2] + 1], exp_status(n, mx, err));
    chk("R6 ownership released", mem[d[11:2]], {1'b0, b[30:0]});
  endtask

  task automatic gap(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int w0, i0;
    void'($urandom(32'd4177));
    init_mem();
    gap(5);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mem_rd reset", 32'(mem_rd), 0);
    chk("R1 mem_wr reset", 32'(mem_wr), 0);
    chk("R1 irq reset", 32'(irq), 0);
    gap(10);
    chk("R1 no access while disabled", 32'(wr_cnt + rd_cnt), 0);

    // Scenario: three-descriptor chain, drop, normal, error, overflow, halt
    set_desc(32'h000, 1, 32'h400, 32'h010);
    set_desc(32'h010, 1, 32'h440, 32'h020);
    set_desc(32'h020, 1, 32'h480, 32'h000);
    cfg_desc_start = 32'h000; cfg_max_words = 16'd8; cfg_skip_unowned = 1'b1;
    cfg_rx_en = 1'b1;
    fill_frame(10);
    send_frame(10, -1);
    gap(15);
    chk("R10 frame starting before ready dropped", 32'(wr_cnt), 0);
    fill_frame(3);  send_frame(3, -1);  gap(15);
    check_frame(32'h000, 32'h400, 3, 8, 0);
    fill_frame(8);  send_frame(8, 2);   gap(15);
    check_frame(32'h010, 32'h440, 8, 8, 1);
    fill_frame(11); send_frame(11, -1); gap(15);
    check_frame(32'h020, 32'h480, 11, 8, 0);
    chk("R2 two reads per descriptor", 32'(rd_cnt), 6);
    chk("R6 one irq per frame", 32'(irq_cnt), 3);
    w0 = wr_cnt;
    fill_frame(4); send_frame(4, -1); gap(15);
    chk("R7 halted engine writes nothing", 32'(wr_cnt), 32'(w0));

    // Scenario: software-owned descriptor skipped
    cfg_rx_en = 1'b0; gap(5);
    set_desc(32'h030, 0, 32'h4C0, 32'h040);
    set_desc(32'h040, 1, 32'h500, 32'h000);
    cfg_desc_start = 32'h030; i0 = irq_cnt;
    cfg_rx_en = 1'b1; gap(15);
    chk("R8 skip raises no irq", 32'(irq_cnt), 32'(i0));
    fill_frame(5); send_frame(5, -1); gap(15);
    check_frame(32'h040, 32'h500, 5, 8, 0);
    chk("R8 skipped word0 untouched", mem[32'h030 >> 2], {1'b0, 31'h4C0});
    chk("R8 skipped status untouched", mem[(32'h030 >> 2) + 1], 32'h0);
    chk("R8 skipped buffer untouched", mem[32'h4C0 >> 2], sentinel(32'h4C0));

    // Scenario: software-owned descriptor halts with interrupt
    cfg_rx_en = 1'b0; gap(5);
    set_desc(32'h050, 0, 32'h540, 32'h060);
    set_desc(32'h060, 1, 32'h580, 32'h000);
    cfg_desc_start = 32'h050; cfg_skip_unowned = 1'b0; i0 = irq_cnt;
    cfg_rx_en = 1'b1; gap(15);
    chk("R9 irq on unowned descriptor", 32'(irq_cnt), 32'(i0 + 1));
    w0 = wr_cnt;
    fill_frame(4); send_frame(4, -1); gap(15);
    chk("R9 halted after unowned", 32'(wr_cnt), 32'(w0));
    chk("R9 next buffer untouched", mem[32'h580 >> 2], sentinel(32'h580));

    // Scenario: enable cleared mid-frame
    cfg_rx_en = 1'b0; gap(5);
    set_desc(32'h070, 1, 32'h5C0, 32'h080);
    set_desc(32'h080, 1, 32'h600, 32'h000);
    cfg_desc_start = 32'h070;
    cfg_rx_en = 1'b1; gap(10);
    fill_frame(6);
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_data = frame_d[i]; in_last = (i == 5); in_err = 1'b0;
      if (i == 2) cfg_rx_en = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    gap(15);
    check_frame(32'h070, 32'h5C0, 6, 8, 0);
    w0 = wr_cnt;
    fill_frame(3); send_frame(3, -1); gap(15);
    chk("R11 stopped after finishing frame", 32'(wr_cnt), 32'(w0));
    chk("R11 following descriptor still owned", mem[32'h080 >> 2], {1'b1, 31'h600});

    // Random rounds with restart from the start register
    for (int r = 0; r < 3; r++) begin
      int mx;
      gap(5);
      init_mem();
      mx = 4 + int'($urandom % 9);
      cfg_max_words = 16'(mx);
      for (int k = 0; k < 8; k++)
        set_desc(32'h100 + 32'(16 * k), 1, 32'h400 + 32'(64 * k),
                 (k == 7) ? 32'h0 : 32'h100 + 32'(16 * (k + 1)));
      cfg_desc_start = 32'h100; cfg_skip_unowned = 1'b1;
      cfg_rx_en = 1'b1; gap(10);
      for (int k = 0; k < 8; k++) begin
        int n, ea;
        n  = 1 + int'($urandom % (mx + 4));
        ea = ($urandom % 4 == 0) ? int'($urandom % n) : -1;
        fill_frame(n); send_frame(n, ea); gap(15);
        check_frame(32'h100 + 32'(16 * k), 32'h400 + 32'(64 * k), n, mx, ea >= 0);
      end
      w0 = wr_cnt;
      fill_frame(2); send_frame(2, -1); gap(15);
      chk("R7 halt at end of random chain", 32'(wr_cnt), 32'(w0));
      cfg_rx_en = 1'b0;
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule